// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A small combinational datapath slice that takes two operand words and, for the same operands, forms a sum from a selectable-operand adder, a bitwise logic result, a one-position right shift and a one-position left shift. A per-bit four-way selector, driven by the two upper bits of a four-bit select word, decides which of these four sources reaches each result bit. The two lower bits of the select word, together with a carry input, pick the adder's second operand. The same two lower bits alone pick the logic function.

The shift paths take every result bit from its neighbouring operand bit. A separate two-bit fill-type input decides what enters the vacated end: zero, the bit that leaves the other end, or the sign bit. Along with the result, the unit reports the adder carry-out, a signed overflow flag and a flag that marks a sign change on a left shift. The unit has no storage. It sits between a register file and its write-back bus.

Top module: `alsu_top`

## Requirements
- R1: `unit_sel[3:2]` selects the result source: 00 adder, 01 logic, 10 shift right, 11 shift left.
- R2: In adder mode the result is (op_a + Y + carry_in) mod 2^WIDTH. Y is selected by `unit_sel[1:0]`: 00 gives op_b, 01 gives ~op_b, 10 gives all zeros, 11 gives all ones.
- R3: In adder mode `carry_out` is the carry out of the top bit. `arith_ovf` is set when the signed result overflows, that is, when the carries into and out of the top bit differ. Both flags are 0 in every other mode.
- R4: In logic mode `unit_sel[1:0]` selects the function: 00 op_a XOR op_b, 01 OR, 10 AND, 11 ~op_a.
- R5: On a shift right, result bit i equals op_a bit i+1. The top bit is filled according to `fill_kind`: 00 and 11 give 0 (logical), 01 gives op_a bit 0 (circular), 10 gives op_a top bit (arithmetic).
- R6: On a shift left, result bit i equals op_a bit i-1. Bit 0 is filled with op_a top bit when `fill_kind` is 01 (circular), and with 0 otherwise.
- R7: `shl_sign_flip` equals op_a[WIDTH-1] XOR op_a[WIDTH-2] while a shift left is selected, and is 0 otherwise.
- R8: `fill_kind` has no effect on any output in adder or logic mode. `carry_in` has no effect on any output outside adder mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand; the operand that is shifted |
| op_b | input | WIDTH | Second operand |
| unit_sel | input | 4 | [3:2] result source, [1:0] adder operand or logic function |
| carry_in | input | 1 | Adder carry input |
| fill_kind | input | 2 | Fill rule for the vacated bit on a shift |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry-out, 0 outside adder mode |
| arith_ovf | output | 1 | Adder signed overflow, 0 outside adder mode |
| shl_sign_flip | output | 1 | Sign change on a left shift |

## Verification
The adder flags and the shift sign-change flag are computed in parallel from the same operand. An operand such as 0100 can therefore both overflow the adder and change sign when shifted left. The bench drives such operands in all four modes, both from directed vectors and from random ones. It then checks that only the flag belonging to the selected mode is raised. It also checks that the two flags are never set in the same cycle.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        SRC_ADD = 2'b00,
        SRC_LOG = 2'b01,
        SRC_SHR = 2'b10,
        SRC_SHL = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ROT  = 2'b01,
        FILL_SIGN = 2'b10,
        FILL_ZALT = 2'b11
    } fill_e;

    typedef struct packed {
        logic cout;
        logic ovf;
    } add_flags_t;

    function automatic logic logic_bit(input logic [1:0] fn, input logic a, input logic b);
        case (fn)
            2'b00:   return a ^ b;
            2'b01:   return a | b;
            2'b10:   return a & b;
            default: return ~a;
        endcase
    endfunction

    function automatic logic y_bit(input logic [1:0] pick, input logic b);
        case (pick)
            2'b00:   return b;
            2'b01:   return ~b;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       pick,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output add_flags_t       flags
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] y;
    logic [WIDTH:0]   full;

    for (genvar i = 0; i < WIDTH; i++) begin : g_y
        assign y[i] = y_bit(pick, b[i]);
    end

    always_comb begin
        full       = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum        = full[TOP:0];
        flags.cout = full[WIDTH];
        // carry into top bit recovered from the top-bit sum
        flags.ovf  = (a[TOP] ^ y[TOP] ^ full[TOP]) ^ full[WIDTH];
    end
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign res[i] = logic_bit(fn, a[i], b[i]);
    end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift
    import alsu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  fill_e            kind,
    output logic [WIDTH-1:0] right_src,
    output logic [WIDTH-1:0] left_src,
    output logic             sign_change
);
    localparam int TOP = WIDTH - 1;

    logic fill_r;
    logic fill_l;

    always_comb begin
        case (kind)
            FILL_ROT: begin
                fill_r = a[0];
                fill_l = a[TOP];
            end
            FILL_SIGN: begin
                fill_r = a[TOP];
                fill_l = 1'b0;
            end
            default: begin
                fill_r = 1'b0;
                fill_l = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_nb
        if (i == TOP) begin : g_top
            assign right_src[i] = fill_r;
        end else begin : g_mid_r
            assign right_src[i] = a[i+1];
        end
        if (i == 0) begin : g_low
            assign left_src[i] = fill_l;
        end else begin : g_mid_l
            assign left_src[i] = a[i-1];
        end
    end

    assign sign_change = a[TOP] ^ a[TOP-1];
endmodule

// File: rtl/alsu_top.sv
module alsu_top
    import alsu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       unit_sel,
    input  logic             carry_in,
    input  logic [1:0]       fill_kind,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             arith_ovf,
    output logic             shl_sign_flip
);
    src_e             src;
    logic [WIDTH-1:0] add_res;
    logic [WIDTH-1:0] log_res;
    logic [WIDTH-1:0] shr_res;
    logic [WIDTH-1:0] shl_res;
    add_flags_t       add_fl;
    logic             sgn_chg;

    assign src = src_e'(unit_sel[3:2]);

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(op_a), .b(op_b), .pick(unit_sel[1:0]), .cin(carry_in),
        .sum(add_res), .flags(add_fl)
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(op_a), .b(op_b), .fn(unit_sel[1:0]), .res(log_res)
    );

    alsu_shift #(.WIDTH(WIDTH)) u_shift (
        .a(op_a), .kind(fill_e'(fill_kind)),
        .right_src(shr_res), .left_src(shl_res), .sign_change(sgn_chg)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        always_comb begin
            case (src)
                SRC_ADD: result[i] = add_res[i];
                SRC_LOG: result[i] = log_res[i];
                SRC_SHR: result[i] = shr_res[i];
                default: result[i] = shl_res[i];
            endcase
        end
    end

    assign carry_out     = (src == SRC_ADD) & add_fl.cout;
    assign arith_ovf     = (src == SRC_ADD) & add_fl.ovf;
    assign shl_sign_flip = (src == SRC_SHL) & sgn_chg;
endmodule

// File: rtl/alsu_checker.sv
module alsu_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [3:0]       unit_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             arith_ovf,
    input logic             shl_sign_flip
);
    always_comb begin
        if (unit_sel[3:2] != 2'b00) begin
            AST_NO_ADD_FLAGS: assert (!carry_out && !arith_ovf); // R3
        end
        if (unit_sel[3:2] != 2'b11) begin
            AST_FLIP_ONLY_SHL: assert (!shl_sign_flip); // R7
        end
        if (unit_sel[3:2] == 2'b10) begin
            AST_SHR_BODY: assert (result[WIDTH-2:0] == op_a[WIDTH-1:1]); // R5
        end
        if (unit_sel[3:2] == 2'b11) begin
            AST_SHL_BODY: assert (result[WIDTH-1:1] == op_a[WIDTH-2:0]); // R6
        end
        if (unit_sel == 4'b0111) begin
            AST_LOGIC_NOT: assert (result == ~op_a); // R4
        end
        AST_FLAGS_EXCLUSIVE: assert (!(arith_ovf && shl_sign_flip)); // R1
    end
endmodule

bind alsu_top alsu_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a(op_a), .unit_sel(unit_sel), .result(result),
    .carry_out(carry_out), .arith_ovf(arith_ovf), .shl_sign_flip(shl_sign_flip)
);

// File: tb/tb_alsu_top.sv
module tb_alsu_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   unit_sel = '0;
    logic         carry_in = 1'b0;
    logic [1:0]   fill_kind = '0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         arith_ovf;
    logic         shl_sign_flip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alsu_top #(.WIDTH(W)) dut (
        .op_a(op_a), .op_b(op_b), .unit_sel(unit_sel), .carry_in(carry_in),
        .fill_kind(fill_kind), .result(result), .carry_out(carry_out),
        .arith_ovf(arith_ovf), .shl_sign_flip(shl_sign_flip)
    );

    // expected outputs packed as {flip, ovf, cout, result}
    function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [3:0] s, input logic ci,
                                           input logic [1:0] fk);
        logic [W-1:0] r, y;
        logic co, ov, fl;
        int sa, sy, ssum, us;
        co = 0; ov = 0; fl = 0; r = '0;
        case (s[3:2])
            2'b00: begin
                case (s[1:0])
                    2'b00: y = b;
                    2'b01: y = ~b;
                    2'b10: y = '0;
                    default: y = '1;
                endcase
                us = int'(a) + int'(y) + int'(ci);
                r  = W'(us);
                co = (us >= (1 << W));
                sa = int'(a) - ((a[W-1]) ? (1 << W) : 0);
                sy = int'(y) - ((y[W-1]) ? (1 << W) : 0);
                ssum = sa + sy + int'(ci);
                ov = (ssum > (1 << (W-1)) - 1) || (ssum < -(1 << (W-1)));
            end
            2'b01: begin
                case (s[1:0])
                    2'b00: r = a ^ b;
                    2'b01: r = a | b;
                    2'b10: r = a & b;
                    default: r = ~a;
                endcase
            end
            2'b10: begin
                r = a >> 1;
                if (fk == 2'b01) r[W-1] = a[0];
                else if (fk == 2'b10) r[W-1] = a[W-1];
            end
            default: begin
                r = a << 1;
                if (fk == 2'b01) r[0] = a[W-1];
                fl = a[W-1] ^ a[W-2];
            end
        endcase
        return {fl, ov, co, r};
    endfunction

    task automatic check(input string tag, input logic [W+2:0] got, input logic [W+2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h sel=%b ci=%b fk=%b got=%h expected=%h",
                     tag, op_a, op_b, unit_sel, carry_in, fill_kind, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] s);
        case (s[3:2])
            2'b00: return "R2/R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6/R7";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] s,
                         input logic ci, input logic [1:0] fk, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; unit_sel = s; carry_in = ci; fill_kind = fk;
        @(posedge clk); #1;
        check(tag, {shl_sign_flip, arith_ovf, carry_out, result}, model(a, b, s, ci, fk));
    endtask

    logic [W+2:0] ref_out;

    initial begin
        void'($urandom(32'h5EED_A15));
        // idle state: all-zero inputs give a zero result and clear flags (R2, R3)
        apply('0, '0, 4'b0000, 1'b0, 2'b00, "R3 idle");
        // R1: same operands through every source
        for (int u = 0; u < 4; u++) apply(4'b1011, 4'b0110, {u[1:0], 2'b01}, 1'b1, 2'b01, "R1");
        // R2/R3 corners: carry out, signed overflow, subtract
        apply(4'b1111, 4'b0001, 4'b0000, 1'b0, 2'b00, "R3 carry");
        apply(4'b0111, 4'b0001, 4'b0000, 1'b0, 2'b00, "R3 overflow");
        apply(4'b0011, 4'b0101, 4'b0001, 1'b1, 2'b00, "R2 subtract");
        apply(4'b1000, 4'b0000, 4'b0011, 1'b0, 2'b00, "R2 decrement");
        apply(4'b0111, 4'b0000, 4'b0010, 1'b1, 2'b00, "R2 increment");
        // R5/R6: each fill kind on a distinctive operand
        for (int k = 0; k < 4; k++) begin
            apply(4'b1001, 4'b0000, 4'b1000, 1'b0, k[1:0], "R5");
            apply(4'b1001, 4'b0000, 4'b1100, 1'b0, k[1:0], "R6");
        end
        // R7: sign change and no change; same operand overflows adder (concurrent flags)
        apply(4'b0100, 4'b0000, 4'b1100, 1'b0, 2'b00, "R7 flip");
        apply(4'b1100, 4'b0000, 4'b1100, 1'b0, 2'b00, "R7 keep");
        apply(4'b0100, 4'b0100, 4'b0000, 1'b0, 2'b00, "R3 ovf only");
        // R8: fill_kind and carry_in are ignored outside their modes
        for (int fn = 0; fn < 4; fn++) begin
            ref_out = model(4'b1010, 4'b0110, {2'b01, fn[1:0]}, 1'b0, 2'b00);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                op_a = 4'b1010; op_b = 4'b0110; unit_sel = {2'b01, fn[1:0]};
                carry_in = k[0]; fill_kind = k[1:0];
                @(posedge clk); #1;
                check("R8", {shl_sign_flip, arith_ovf, carry_out, result}, ref_out);
            end
        end
        for (int k = 0; k < 4; k++)
            apply(4'b0110, 4'b0011, 4'b0000, 1'b1, k[1:0], "R8 adder");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] s;
            s = 4'($urandom);
            apply(W'($urandom), W'($urandom), s, 1'($urandom), 2'($urandom), tag_of(s));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule